// File: doc/BRIEF.md
# SPI NOR Flash Target Emulator

This block is an SPI slave that a master can treat as a small serial NOR flash. It samples the SPI pins with its own system clock, assembles bytes, and reads the first byte after chip-select falls as a command. The block holds a byte array, a status byte and a write-enable latch. It serves sequential reads, page programs, sector and whole-array erases, status reads and status writes, and it follows the usual NOR rules. Any command that changes the array or the status needs the latch set beforehand. Programming can only clear bits. Erase returns bytes to 0xFF. While an operation is busy, the status read is the only command the block answers.

The time an operation stays busy comes from the `busy_cycles` input, so a test environment can make program and erase short or long. Erase runs one byte per clock through the selected range, so an erase stays busy for at least as many cycles as the range has bytes. The array size, page size and sector size are parameters. The incoming 24-bit address is reduced to the low `ADDR_W` bits.

Top module: `spi_nor_target`

## Requirements
- R1: SPI runs in mode 3. SCK idles high. MOSI is sampled on rising SCK edges and MISO changes after falling edges, most significant bit first. MISO is 0 while chip-select (active low) is high.
- R2: Opcode 0x05 returns the status byte in every byte clocked after the opcode until chip-select rises. Status bit 0 is write-in-progress, bit 1 is the write-enable latch and bits 7:2 are a stored user field. The status byte is 0x00 after reset.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Both take effect as soon as the opcode byte completes.
- R4: Opcode 0x03 is followed by a 24-bit address, most significant byte first. Every further byte returns the array byte at the next ascending address until chip-select rises. The address is taken modulo the array size (low `ADDR_W` bits), so by default 0x001010 reaches 0x010.
- R5: Opcode 0x02 plus an address writes each following data byte as old AND data. The address advances within its 256-byte page and wraps from the page's last byte to its first.
- R6: Opcode 0xD8 plus an address sets every byte of the enclosing sector (2^`SECTOR_W` bytes) to 0xFF when chip-select rises. Bytes outside that sector are left unchanged.
- R7: Opcode 0xC7 sets the whole array to 0xFF when chip-select rises.
- R8: Opcodes 0x02, 0xD8, 0xC7 and 0x01 are ignored unless the write-enable latch is set when their opcode byte completes.
- R9: Write-in-progress rises after the chip-select rise that ends an erase, or a program with at least one data byte. It stays high for max(`busy_cycles`,1) cycles and until the erase has covered its range. The write-enable latch clears when write-in-progress falls.
- R10: While write-in-progress is set, every opcode other than 0x05 is ignored: reads return 0x00 and the latch commands have no effect.
- R11: Opcode 0x01 with the latch set stores bits 7:2 of its first data byte into the status user field when chip-select rises. It clears the latch and does not set write-in-progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the master, idles high |
| spi_csn | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| busy_cycles | input | BUSY_W | Minimum busy time of a program or erase, in clock cycles |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The hardest state to reach is a command arriving while write-in-progress is still high. The block has to refuse it and stay reachable through the status read alone. The bench sets `busy_cycles` far longer than the several SPI frames that follow a program. It then issues a latch set and a read of a known non-erased byte inside that window, and it proves both were ignored by the 0x00 read data and by the status after the operation ends. Wrapping within a page, and reads that run sequentially across a page boundary, are reached by programming near the end of a page and reading back from both sides of the boundary.

// File: rtl/spi_nor_target_pkg.sv
package spi_nor_target_pkg;

  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_RSTAT  = 8'h05;
  localparam logic [7:0] OP_WSTAT  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_CERASE = 8'hC7;

  localparam int ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ADDR,
    ST_RD,
    ST_PP,
    ST_STAT,
    ST_WRSR,
    ST_ERASE,
    ST_IGNORE
  } cmd_state_t;

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              sel,
  output logic              cs_start,
  output logic              cs_end,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0]        sck_s;
  logic [1:0]        cs_s;
  logic [1:0]        mosi_s;
  logic              sel_q;
  logic              sck_rise;
  logic              sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '1;
      cs_s   <= '1;
      mosi_s <= '0;
      sel_q  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      cs_s   <= {cs_s[0], csn};
      mosi_s <= {mosi_s[0], mosi};
      sel_q  <= sel;
    end
  end

  assign sel      = ~cs_s[1];
  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];
  assign cs_start = sel & ~sel_q;
  assign cs_end   = ~sel & sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_sh    <= '0;
      miso     <= 1'b0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
      tx_sh    <= '0;
      miso     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        rx_sh <= {rx_sh[BYTE_W-3:0], mosi_s[1]};
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh, mosi_s[1]};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (sck_fall) begin
        miso  <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end else if (tx_load) begin
        tx_sh <= tx_byte;
      end
    end
  end

  // MISO is quiet outside a frame
  assert_miso_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (miso == 1'b0));

  // a byte takes several SCK edges, never two back-to-back strobes
  assert_rx_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= (len == '0) ? CNT_W'(1) : len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/flash_erase_walker.sv
module flash_erase_walker #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  output logic              active,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ptr    <= '0;
      last_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      ptr    <= first;
      last_q <= last;
    end else if (active) begin
      if (ptr == last_q) active <= 1'b0;
      else               ptr    <= ptr + 1'b1;
    end
  end

  assert_walk_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && ptr == $past(first)));

endmodule

// File: rtl/spi_nor_target.sv
module spi_nor_target
  import spi_nor_target_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 9,
  parameter int BUSY_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  input  logic [BUSY_W-1:0] busy_cycles,
  output logic              spi_miso
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SHL   = ADDR_W - 8;
  localparam int ACW   = $clog2(ADDR_BYTES);

  // address arithmetic, kept in one place
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  function automatic logic [ADDR_W-1:0] sector_first(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] sector_last(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECTOR_W], {SECTOR_W{1'b1}}};
  endfunction

  logic              sel, cs_start, cs_end, rx_valid;
  logic [7:0]        rx_byte, tx_byte;
  cmd_state_t        state;
  logic [7:0]        cmd;
  logic [ACW-1:0]    addr_n;
  logic [ADDR_W-1:0] ptr;
  logic              wel;
  logic [5:0]        user_bits;
  logic [5:0]        wrsr_bits;
  logic              wrsr_got;
  logic              pp_any;
  logic              wip, wip_q, tmr_busy, walk_busy;
  logic [ADDR_W-1:0] walk_ptr, walk_first, walk_last;
  logic [ADDR_W-1:0] full_addr;
  logic [7:0]        status;
  logic [7:0]        mem [DEPTH];

  // named internal events
  logic pp_we, erase_go, prog_go, wrsr_commit, busy_done;

  assign full_addr   = {ptr[SHL-1:0], rx_byte};
  assign status      = {user_bits, wel, wip};
  assign wip         = tmr_busy | walk_busy;
  assign pp_we       = rx_valid && (state == ST_PP);
  assign erase_go    = cs_end && (state == ST_ERASE);
  assign prog_go     = cs_end && (state == ST_PP) && pp_any;
  assign wrsr_commit = cs_end && (state == ST_WRSR) && wrsr_got;
  assign busy_done   = wip_q && !wip;
  assign walk_first  = (cmd == OP_CERASE) ? '0 : sector_first(ptr);
  assign walk_last   = (cmd == OP_CERASE) ? '1 : sector_last(ptr);

  spi_byte_link #(.BYTE_W(8)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .tx_load(rx_valid), .tx_byte(tx_byte), .miso(spi_miso), .sel(sel),
    .cs_start(cs_start), .cs_end(cs_end), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  flash_busy_timer #(.CNT_W(BUSY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(erase_go | prog_go), .len(busy_cycles),
    .busy(tmr_busy)
  );

  flash_erase_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(erase_go), .first(walk_first),
    .last(walk_last), .active(walk_busy), .ptr(walk_ptr)
  );

  // response byte, loaded into the shifter when a byte completes
  always_comb begin
    tx_byte = 8'h00;
    case (state)
      ST_OP:   if (rx_byte == OP_RSTAT) tx_byte = status;
      ST_ADDR: if (addr_n == ACW'(ADDR_BYTES - 1) && cmd == OP_READ)
                 tx_byte = mem[full_addr];
      ST_RD:   tx_byte = mem[ptr];
      ST_STAT: tx_byte = status;
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OP;
      cmd       <= '0;
      addr_n    <= '0;
      ptr       <= '0;
      wel       <= 1'b0;
      user_bits <= '0;
      wrsr_bits <= '0;
      wrsr_got  <= 1'b0;
      pp_any    <= 1'b0;
      wip_q     <= 1'b0;
    end else begin
      wip_q <= wip;
      if (cs_start || cs_end) begin
        state    <= ST_OP;
        addr_n   <= '0;
        pp_any   <= 1'b0;
        wrsr_got <= 1'b0;
      end
      if (wrsr_commit) begin
        user_bits <= wrsr_bits;
        wel       <= 1'b0;
      end
      if (rx_valid) begin
        case (state)
          ST_OP: begin
            cmd <= rx_byte;
            if (wip) begin
              state <= (rx_byte == OP_RSTAT) ? ST_STAT : ST_IGNORE;
            end else begin
              case (rx_byte)
                OP_WEN:    begin wel <= 1'b1; state <= ST_IGNORE; end
                OP_WDIS:   begin wel <= 1'b0; state <= ST_IGNORE; end
                OP_RSTAT:  state <= ST_STAT;
                OP_READ:   state <= ST_ADDR;
                OP_WSTAT:  state <= wel ? ST_WRSR : ST_IGNORE;
                OP_PROG,
                OP_SERASE: state <= wel ? ST_ADDR : ST_IGNORE;
                OP_CERASE: state <= wel ? ST_ERASE : ST_IGNORE;
                default:   state <= ST_IGNORE;
              endcase
            end
          end
          ST_ADDR: begin
            ptr <= full_addr;
            if (addr_n == ACW'(ADDR_BYTES - 1)) begin
              case (cmd)
                OP_READ: begin state <= ST_RD; ptr <= full_addr + 1'b1; end
                OP_PROG: state <= ST_PP;
                default: state <= ST_ERASE;
              endcase
            end else begin
              addr_n <= addr_n + 1'b1;
            end
          end
          ST_RD: ptr <= ptr + 1'b1;
          ST_PP: begin
            ptr    <= page_step(ptr);
            pp_any <= 1'b1;
          end
          ST_WRSR: begin
            if (!wrsr_got) wrsr_bits <= rx_byte[7:2];
            wrsr_got <= 1'b1;
          end
          default: ;
        endcase
      end
      if (busy_done) wel <= 1'b0;
    end
  end

  // array write port: erase walk or program AND
  always_ff @(posedge clk) begin
    if (walk_busy)  mem[walk_ptr] <= 8'hFF;
    else if (pp_we) mem[ptr]      <= mem[ptr] & rx_byte;
  end

  assert_wip_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (state == ST_OP || state == ST_STAT || state == ST_IGNORE));

  assert_wel_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |=> !wel);

  assert_prog_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pp_we |-> wel);

  assert_wrsr_no_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |=> (!wel && !tmr_busy && !walk_busy));

endmodule

// File: tb/spi_nor_target_tb.sv
module spi_nor_target_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b1;
  logic        csn = 1'b1;
  logic        mosi = 1'b0;
  logic [15:0] busy_cycles = 16'd20;
  logic        miso;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];
  logic [7:0] s;

  always #2 clk = ~clk;

  spi_nor_target u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .busy_cycles(busy_cycles), .spi_miso(miso)
  );

  // {address[15:0], program byte, expected read-back}
  localparam logic [31:0] VEC [8] = '{
    {16'h0010, 8'hA5, 8'hA5},
    {16'h0010, 8'h3C, 8'h24},
    {16'h0123, 8'h00, 8'h00},
    {16'h07FF, 8'h5A, 8'h5A},
    {16'h0400, 8'hFF, 8'hFF},
    {16'h0123, 8'hFF, 8'h00},
    {16'h0200, 8'h81, 8'h81},
    {16'h1010, 8'hF0, 8'h20}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      sck  = 1'b0;
      mosi = o[b];
      half();
      i[b] = miso;
      sck  = 1'b1;
      half();
    end
  endtask

  task automatic frame_on();
    csn = 1'b0;
    half();
  endtask

  task automatic frame_off();
    half();
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xbyte(a[23:16], d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    frame_on(); xbyte(op, d); frame_off();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    frame_on(); xbyte(8'h05, d); xbyte(8'h00, st); frame_off();
  endtask

  task automatic read_n(input logic [23:0] a, input int n);
    logic [7:0] d;
    frame_on(); xbyte(8'h03, d); send_addr(a);
    for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k]);
    frame_off();
  endtask

  task automatic prog(input logic [23:0] a, input int n);
    logic [7:0] d;
    frame_on(); xbyte(8'h02, d); send_addr(a);
    for (int k = 0; k < n; k++) xbyte(wbuf[k], d);
    frame_off();
  endtask

  task automatic erase_sec(input logic [23:0] a);
    logic [7:0] d;
    frame_on(); xbyte(8'hD8, d); send_addr(a); frame_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    frame_on(); xbyte(8'h01, d); xbyte(v, d); frame_off();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    int guard = 0;
    rdsr(st);
    while (st[0] && guard < 100) begin
      rdsr(st);
      guard++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, s1, s2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R1 miso idle", {7'd0, miso}, 8'h00);
    rdsr(s);
    check("R2 reset status", s, 8'h00);

    // latch control, status repeated in every byte
    cmd1(8'h06);
    frame_on(); xbyte(8'h05, d); xbyte(8'h00, s1); xbyte(8'h00, s2); frame_off();
    check("R3 latch set", s1, 8'h02);
    check("R2 status repeats", s2, 8'h02);
    cmd1(8'h04);
    rdsr(s);
    check("R3 latch cleared", s, 8'h00);

    // whole-array erase as a starting point
    cmd1(8'h06); cmd1(8'hC7);
    rdsr(s);
    check("R9 busy during erase", s, 8'h03);
    wait_idle();
    rdsr(s);
    check("R9 latch clears at end", s, 8'h00);
    read_n(24'h000000, 4);
    for (int k = 0; k < 4; k++) check("R7 erased", rbuf[k], 8'hFF);

    // table of single-byte programs and read-backs (R5 AND rule, R4 address fold)
    for (int v = 0; v < 8; v++) begin
      cmd1(8'h06);
      wbuf[0] = VEC[v][15:8];
      prog({8'h00, VEC[v][31:16]}, 1);
      wait_idle();
      read_n({8'h00, VEC[v][31:16]}, 1);
      check("R5 R4 table", rbuf[0], VEC[v][7:0]);
    end

    // program without latch
    wbuf[0] = 8'h00;
    prog(24'h000300, 1);
    rdsr(s);
    check("R8 no busy without latch", s, 8'h00);
    read_n(24'h000300, 1);
    check("R8 program ignored", rbuf[0], 8'hFF);

    // page wrap and sequential read across a page boundary
    cmd1(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    prog(24'h0001FE, 4);
    wait_idle();
    read_n(24'h000100, 2);
    check("R5 wrap first", rbuf[0], 8'h33);
    check("R5 wrap second", rbuf[1], 8'h44);
    read_n(24'h0001FE, 3);
    check("R4 seq 0", rbuf[0], 8'h11);
    check("R4 seq 1", rbuf[1], 8'h22);
    check("R4 seq cross page", rbuf[2], 8'h81);

    // commands during a long busy window
    busy_cycles = 16'd2000;
    cmd1(8'h06);
    wbuf[0] = 8'h0F;
    prog(24'h000040, 1);
    rdsr(s);
    check("R9 busy after program", s, 8'h03);
    cmd1(8'h04);
    read_n(24'h0007FF, 1);
    check("R10 read ignored while busy", rbuf[0], 8'h00);
    rdsr(s);
    check("R10 latch clear ignored", s, 8'h03);
    wait_idle();
    cmd1(8'h06);
    busy_cycles = 16'd2000;
    wbuf[0] = 8'hF0;
    prog(24'h000041, 1);
    cmd1(8'h06);
    wait_idle();
    rdsr(s);
    check("R10 latch set ignored", s, 8'h00);
    busy_cycles = 16'd20;
    read_n(24'h000040, 2);
    check("R5 busy program byte", rbuf[0], 8'h0F);
    check("R5 second program byte", rbuf[1], 8'hF0);

    // chip erase without latch
    cmd1(8'hC7);
    rdsr(s);
    check("R8 chip erase ignored", s, 8'h00);
    read_n(24'h000200, 1);
    check("R8 data kept", rbuf[0], 8'h81);

    // sector erase
    cmd1(8'h06);
    erase_sec(24'h000010);
    wait_idle();
    read_n(24'h000010, 1);
    check("R6 sector byte", rbuf[0], 8'hFF);
    read_n(24'h000123, 1);
    check("R6 sector byte 2", rbuf[0], 8'hFF);
    read_n(24'h0001FF, 2);
    check("R6 sector end", rbuf[0], 8'hFF);
    check("R6 next sector kept", rbuf[1], 8'h81);
    read_n(24'h0007FF, 1);
    check("R6 far byte kept", rbuf[0], 8'h5A);

    // status write
    cmd1(8'h06);
    wrsr(8'hFE);
    rdsr(s);
    check("R11 status write", s, 8'hFC);
    wrsr(8'h00);
    rdsr(s);
    check("R11 R8 status write without latch", s, 8'hFC);

    // final chip erase
    cmd1(8'h06); cmd1(8'hC7);
    wait_idle();
    read_n(24'h000200, 1);
    check("R7 chip erase", rbuf[0], 8'hFF);
    read_n(24'h0007FF, 1);
    check("R7 chip erase top", rbuf[0], 8'hFF);
    rdsr(s);
    check("R9 R2 final status", s, 8'hFC);
    check("R1 miso idle end", {7'd0, miso}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule